// File: doc/BRIEF.md
# MSI Coherence Controller for a Direct-Mapped Writeback Cache

This block keeps a small direct-mapped writeback cache coherent with its peers on a shared snooping bus, using three line states: Modified (sole valid copy, memory stale), Shared (memory consistent, other caches may also hold the line) and Invalid. Each line is one data word. Processor reads and writes either hit locally or become bus transactions. A read miss fetches the line for sharing. A write to a line this cache does not own fetches the line with ownership. Replacing a dirty line first writes it back to memory.

The controller also watches every transaction other caches place on the bus. A snooped read of a line held Modified makes this cache drive the line on its flush output, so that the requester and memory both take the current data, and the line drops to Shared. A snooped ownership request removes the local copy, flushing it first if it is dirty. Snoops are handled every cycle and take priority over the acceptance of a new processor request.

Top module: `msi_ctrl`

## Requirements
- R1: After reset every line is Invalid, and bus_req, cpu_done and flush_valid are low.
- R2: A processor read that misses issues bus command 1 (shared read) at the request address, returns bus_rdata on cpu_rdata, and leaves the line Shared; a read that hits causes no bus request and returns the stored word.
- R3: A processor write to a line that is Invalid or Shared issues bus command 2 (read with ownership) at the request address and leaves the line Modified holding the written word.
- R4: A processor write that hits a Modified line completes with no bus request, and can be repeated any number of times without bus traffic.
- R5: A miss whose set holds a Modified line with another tag first issues bus command 3 (writeback) with the victim address and its dirty word, then the fetch for the new address.
- R6: A miss whose set holds a Shared line with another tag replaces it with no writeback.
- R7: A snooped command 1 that hits a Modified line raises flush_valid with the line's word one cycle later and leaves the line Shared.
- R8: A snooped command 2 that hits a Modified line raises flush_valid with the line's word one cycle later and leaves the line Invalid.
- R9: A snooped command 2 that hits a Shared line leaves it Invalid with no flush.
- R10: A snoop that misses, a snooped command 1 on a Shared line, and a snooped command 0 or 3 cause no flush and no state change.
- R11: While a bus request waits for bus_gnt and bus_ready together, bus_req stays high and bus_cmd (never 0) and bus_addr stay unchanged; a transaction completes in the cycle both are high.
- R12: A processor request is not accepted in a cycle in which snp_valid is high; it is taken in the first later cycle without a snoop.
- R13: cpu_done is a one-cycle pulse, and cpu_rdata carries the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address (low bits select the set) |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 1 shared read, 2 read with ownership, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_ready | input | 1 | Memory side finishes the transaction |
| bus_rdata | input | DATA_W | Fetched line data |
| snp_valid | input | 1 | A peer transaction is visible on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | This cache supplies a dirty line |
| flush_data | output | DATA_W | Supplied line data |

## Verification
A wrong line state is invisible until that set is touched again; it then shows as the wrong bus command, a missing or spurious writeback, a missing or spurious flush one cycle after a snoop, or stale data on cpu_rdata. The bench therefore keeps its own model of every set and memory word and revisits a small pool of addresses so that each line state is read back through a later access within a few operations. Handshake faults show within the same transaction as a changed command or address while waiting for grant.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LINE_INV = 2'd0,
        LINE_SHD = 2'd1,
        LINE_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_EVICT = 2'd1,
        CTL_FILL  = 2'd2
    } ctl_e;

endpackage

// File: rtl/msi_lookup.sv
module msi_lookup
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [1:0]       line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic             owned,
    output logic             dirty_victim
);
    logic tag_eq;

    always_comb begin
        tag_eq       = (line_tag == req_tag);
        hit          = (line_st != LINE_INV) && tag_eq;
        owned        = (line_st == LINE_MOD);
        dirty_victim = owned && !tag_eq;
    end
endmodule

// File: rtl/msi_snoop_line.sv
module msi_snoop_line
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             set_sel,
    input  logic [1:0]       line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic [1:0]       nxt_st,
    output logic             flush
);
    logic hit;

    always_comb begin
        hit    = snp_valid && set_sel && (line_st != LINE_INV) && (line_tag == snp_tag);
        nxt_st = line_st;
        flush  = 1'b0;
        if (hit) begin
            case (snp_cmd)
                CMD_RD: begin
                    if (line_st == LINE_MOD) begin
                        nxt_st = LINE_SHD;
                        flush  = 1'b1;
                    end
                end
                CMD_RDX: begin
                    nxt_st = LINE_INV;
                    flush  = (line_st == LINE_MOD);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_e                          ctl;
        logic [SETS-1:0][1:0]          st;
        logic [SETS-1:0][TAG_W-1:0]    tag;
        logic [SETS-1:0][DATA_W-1:0]   dat;
        logic                          req_we;
        logic [ADDR_W-1:0]             req_addr;
        logic [DATA_W-1:0]             req_wdata;
        logic                          done;
        logic [DATA_W-1:0]             rdata;
        logic                          flush;
        logic [DATA_W-1:0]             flush_dat;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic [IDX_W-1:0] cpu_idx, req_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, req_tag, snp_tag;
    logic             lk_hit, lk_owned, lk_dirty_victim;
    logic [SETS-1:0][1:0] snp_st;
    logic [SETS-1:0]      snp_flush;
    logic             victim_dirty;
    logic             bus_go;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = r_q.req_addr[IDX_W-1:0];
    assign req_tag = r_q.req_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    msi_lookup #(.TAG_W(TAG_W)) u_lookup (
        .line_st      (r_q.st[cpu_idx]),
        .line_tag     (r_q.tag[cpu_idx]),
        .req_tag      (cpu_tag),
        .hit          (lk_hit),
        .owned        (lk_owned),
        .dirty_victim (lk_dirty_victim)
    );

    for (genvar g = 0; g < SETS; g++) begin : g_snoop
        msi_snoop_line #(.TAG_W(TAG_W)) u_snoop (
            .snp_valid (snp_valid),
            .snp_cmd   (snp_cmd),
            .snp_tag   (snp_tag),
            .set_sel   (snp_idx == IDX_W'(g)),
            .line_st   (r_q.st[g]),
            .line_tag  (r_q.tag[g]),
            .nxt_st    (snp_st[g]),
            .flush     (snp_flush[g])
        );
    end

    // Bus side outputs depend only on registered state.
    always_comb begin
        victim_dirty = (r_q.st[req_idx] == LINE_MOD);
        bus_req      = 1'b0;
        bus_cmd      = CMD_NONE;
        bus_addr     = r_q.req_addr;
        bus_wdata    = r_q.dat[req_idx];
        case (r_q.ctl)
            CTL_EVICT: begin
                bus_req  = victim_dirty;
                bus_cmd  = CMD_WB;
                bus_addr = {r_q.tag[req_idx], req_idx};
            end
            CTL_FILL: begin
                bus_req = 1'b1;
                bus_cmd = r_q.req_we ? CMD_RDX : CMD_RD;
            end
            default: ;
        endcase
        bus_go = bus_req && bus_gnt && bus_ready;
    end

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        r_d.flush     = |snp_flush;
        r_d.flush_dat = r_q.dat[snp_idx];
        r_d.st        = snp_st;

        case (r_q.ctl)
            CTL_IDLE: begin
                if (cpu_req && !snp_valid && !r_q.done) begin
                    r_d.req_we    = cpu_we;
                    r_d.req_addr  = cpu_addr;
                    r_d.req_wdata = cpu_wdata;
                    if (lk_hit && !cpu_we) begin
                        r_d.done  = 1'b1;
                        r_d.rdata = r_q.dat[cpu_idx];
                    end else if (lk_hit && lk_owned) begin
                        r_d.dat[cpu_idx] = cpu_wdata;
                        r_d.done         = 1'b1;
                    end else if (lk_dirty_victim) begin
                        r_d.ctl = CTL_EVICT;
                    end else begin
                        r_d.ctl = CTL_FILL;
                    end
                end
            end
            CTL_EVICT: begin
                if (!victim_dirty) begin
                    r_d.ctl = CTL_FILL;
                end else if (bus_go) begin
                    r_d.st[req_idx] = LINE_INV;
                    r_d.ctl         = CTL_FILL;
                end
            end
            CTL_FILL: begin
                if (bus_go) begin
                    r_d.st[req_idx]  = r_q.req_we ? LINE_MOD : LINE_SHD;
                    r_d.tag[req_idx] = req_tag;
                    r_d.dat[req_idx] = r_q.req_we ? r_q.req_wdata : bus_rdata;
                    r_d.rdata        = bus_rdata;
                    r_d.done         = 1'b1;
                    r_d.ctl          = CTL_IDLE;
                end
            end
            default: r_d.ctl = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_done    = r_q.done;
    assign cpu_rdata   = r_q.rdata;
    assign flush_valid = r_q.flush;
    assign flush_data  = r_q.flush_dat;

endmodule

// File: rtl/msi_ctrl_chk.sv
module msi_ctrl_chk
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              bus_ready,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              flush_valid
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(bus_gnt && bus_ready) && bus_cmd != CMD_WB)
        |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R11
    cmd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != CMD_NONE));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R7
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ($past(snp_valid) &&
                         ($past(snp_cmd) == CMD_RD || $past(snp_cmd) == CMD_RDX)));

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req);

    // R12
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !bus_req) |=> !cpu_done);
endmodule

bind msi_ctrl msi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_done    (cpu_done),
    .bus_req     (bus_req),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .bus_gnt     (bus_gnt),
    .bus_ready   (bus_ready),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .flush_valid (flush_valid)
);

// File: tb/msi_ctrl_bench.sv
`timescale 1ns/1ps
module msi_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata;
    logic       bus_gnt = 1'b0, bus_ready = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic       flush_valid;
    logic [7:0] flush_data;

    int total = 0, fails = 0;
    bit finished = 0;

    logic [7:0] mem [256];
    logic [1:0] m_st  [4];
    logic [5:0] m_tag [4];
    logic [7:0] m_dat [4];

    always #10 clk = ~clk;

    msi_ctrl u_msi_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .flush_valid(flush_valid), .flush_data(flush_data)
    );

    function automatic logic [7:0] mem_init(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input bit we, input logic [7:0] a, input logic [7:0] wd, input bit snp_hold);
        logic [1:0] idx;
        logic [5:0] tg;
        bit         hit;
        int         exp_n, n;
        logic [1:0] ec [2];
        logic [7:0] ea [2];
        logic [7:0] ewb, exp_rd, rd;
        logic [1:0] lc [4];
        logic [7:0] la [4];
        logic [7:0] lw [4];
        logic [1:0] c0;
        logic [7:0] a0;
        bit         seen, fin;
        int         waitc;
        string      lab;

        idx = a[1:0]; tg = a[7:2];
        hit = (m_st[idx] != 2'd0) && (m_tag[idx] == tg);
        exp_n = 0; exp_rd = m_dat[idx]; ewb = m_dat[idx];
        if (!we && hit) begin
            lab = "R2 read hit";
        end else if (we && hit && m_st[idx] == 2'd2) begin
            lab = "R4 write hit modified";
            m_dat[idx] = wd;
        end else begin
            lab = we ? "R3 ownership fetch" : "R2 read miss";
            if (m_st[idx] == 2'd2 && !hit) begin
                lab = "R5 dirty victim writeback";
                ec[0] = 2'd3; ea[0] = {m_tag[idx], idx}; exp_n = 1;
            end else if (m_st[idx] == 2'd1 && !hit) begin
                lab = "R6 shared victim silent";
            end
            ec[exp_n] = we ? 2'd2 : 2'd1; ea[exp_n] = a; exp_n++;
            exp_rd = mem[a];
            m_st[idx] = we ? 2'd2 : 2'd1;
            m_tag[idx] = tg;
            m_dat[idx] = we ? wd : mem[a];
        end

        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (snp_hold) begin
            snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = a ^ 8'h80;
        end
        n = 0; seen = 0; fin = 0; rd = '0; c0 = '0; a0 = '0;
        waitc = int'($urandom % 3);
        for (int cyc = 0; cyc < 64 && !fin; cyc++) begin
            @(negedge clk);
            bus_gnt = 1'b0; bus_ready = 1'b0;
            if (cyc == 0 && snp_hold) begin
                chk(!cpu_done && !bus_req, "R12 request held off by snoop", {cpu_done, bus_req}, 0);
                chk(!flush_valid, "R10 snoop miss no flush", flush_valid, 0);
                snp_valid = 1'b0;
            end else if (cpu_done) begin
                rd = cpu_rdata; cpu_req = 1'b0; fin = 1;
            end else if (bus_req) begin
                if (!seen) begin
                    seen = 1; c0 = bus_cmd; a0 = bus_addr;
                end else begin
                    chk(bus_cmd == c0 && bus_addr == a0, "R11 request stable while waiting",
                        {bus_cmd, bus_addr}, {c0, a0});
                end
                if (waitc > 0) begin
                    waitc--;
                end else begin
                    if (n < 4) begin
                        lc[n] = bus_cmd; la[n] = bus_addr; lw[n] = bus_wdata;
                    end
                    n++;
                    bus_rdata = mem[bus_addr];
                    if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
                    bus_gnt = 1'b1; bus_ready = 1'b1;
                    seen = 0;
                    waitc = int'($urandom % 3);
                end
            end
        end
        chk(fin, "R13 operation completes", fin, 1);
        cpu_req = 1'b0;
        chk(n == exp_n, {lab, " transaction count"}, n, exp_n);
        for (int i = 0; i < exp_n && i < n; i++) begin
            chk(lc[i] == ec[i], {lab, " command"}, lc[i], ec[i]);
            chk(la[i] == ea[i], {lab, " address"}, la[i], ea[i]);
            if (ec[i] == 2'd3) chk(lw[i] == ewb, "R5 writeback data", lw[i], ewb);
        end
        if (!we) chk(rd == exp_rd, {lab, " data R13"}, rd, exp_rd);
        @(negedge clk);
        chk(!cpu_done, "R13 done is one cycle", cpu_done, 0);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a);
        logic [1:0] idx;
        bit         hit, ef;
        logic [7:0] ed;
        string      lab;

        idx = a[1:0];
        hit = (m_st[idx] != 2'd0) && (m_tag[idx] == a[7:2]);
        ef  = hit && m_st[idx] == 2'd2 && (c == 2'd1 || c == 2'd2);
        ed  = m_dat[idx];
        if (hit && m_st[idx] == 2'd2 && c == 2'd1)      lab = "R7 snoop read on modified";
        else if (hit && m_st[idx] == 2'd2 && c == 2'd2) lab = "R8 snoop ownership on modified";
        else if (hit && m_st[idx] == 2'd1 && c == 2'd2) lab = "R9 snoop ownership on shared";
        else                                            lab = "R10 snoop without effect";
        if (hit) begin
            if (c == 2'd1 && m_st[idx] == 2'd2) m_st[idx] = 2'd1;
            if (c == 2'd2) m_st[idx] = 2'd0;
        end
        if (ef) mem[a] = ed;

        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(flush_valid == ef, {lab, " flush"}, flush_valid, ef);
        if (ef) chk(flush_data == ed, {lab, " flush data"}, flush_data, ed);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 2'd0; m_tag[i] = '0; m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!bus_req && !cpu_done && !flush_valid, "R1 reset outputs low",
            {bus_req, cpu_done, flush_valid}, 0);

        cpu_op(0, 8'h05, 8'h00, 0);   // R2 read miss
        cpu_op(0, 8'h05, 8'h00, 0);   // R2 read hit
        cpu_op(1, 8'h05, 8'hA1, 0);   // R3 upgrade from shared
        cpu_op(1, 8'h05, 8'hA2, 0);   // R4 write hit modified
        cpu_op(1, 8'h05, 8'hA3, 0);   // R4 repeated
        cpu_op(0, 8'h05, 8'h00, 0);   // R2 hit returns written word
        cpu_op(0, 8'h09, 8'h00, 0);   // R5 dirty victim
        cpu_op(0, 8'h05, 8'h00, 0);   // R6 shared victim, reads written-back data
        cpu_op(1, 8'h02, 8'hC4, 0);   // R3 from invalid
        snoop(2'd1, 8'h02);           // R7
        cpu_op(0, 8'h02, 8'h00, 0);   // R7 still readable
        cpu_op(1, 8'h02, 8'hC5, 0);   // R3 needs ownership again
        snoop(2'd1, 8'h02);           // R7
        snoop(2'd2, 8'h02);           // R9
        cpu_op(0, 8'h02, 8'h00, 0);   // miss, flushed data from memory
        cpu_op(1, 8'h03, 8'hD6, 0);
        snoop(2'd2, 8'h03);           // R8
        cpu_op(0, 8'h03, 8'h00, 0);   // R8 line gone
        snoop(2'd1, 8'h13);           // R10 miss
        snoop(2'd1, 8'h03);           // R10 read on shared
        snoop(2'd3, 8'h03);           // R10 writeback snoop
        snoop(2'd0, 8'h03);           // R10 idle command
        cpu_op(0, 8'h03, 8'h00, 1);   // R12 snoop in the same cycle
        cpu_op(1, 8'h0B, 8'h3C, 1);   // R12 on a miss

        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            logic [7:0] a;
            r = $urandom % 8;
            a = 8'($urandom % 16);
            if (r < 3) snoop(2'($urandom % 4), a);
            else       cpu_op(r[0], a, 8'($urandom), (r == 7));
        end

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule